// File: doc/BRIEF.md
# Byte-Range Reservation Monitor

This block keeps the load-linked reservations for one cache line. A small table holds up to `N_SLOTS` reservations; each one records the context that made it and the inclusive span of bytes it covers. A load-linked request opens a reservation over exactly the bytes it read. A store-conditional succeeds only when the same context still holds a reservation that covers every byte the store writes.

Every store removes the reservations whose spans it touches. This includes plain stores and conditional stores, and it applies whether the conditional store succeeds or fails. Reservations on other bytes of the same line stay valid. This means two contexts can work on disjoint words of one line without making each other fail. A line-invalidate pulse removes every reservation at once. It is used when the line is evicted or taken by another agent.

Requests are presented for one cycle each. The load-linked port and the store port are independent and may both be active in the same cycle. The result of a store-conditional appears on the cycle after the request.

Top module: `rsv_monitor`

## Requirements
- R1: A request covers the bytes from its address up to address + bytes − 1. The size code gives the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. Spans never wrap at the top of the address space.
- R2: A store-conditional succeeds only if some valid reservation meets both conditions: its context equals the store's context, and its span contains the store's whole span (store low ≥ entry low and store high ≤ entry high). The verdict is checked against the table as it stood before that cycle's updates. The verdict appears on `sc_ok` in the next cycle, with 1 meaning success and 0 meaning failure.
- R3: Every store, plain or conditional, successful or not, removes each reservation whose span overlaps it. Two spans overlap when store low ≤ entry high and store high ≥ entry low. Reservations that do not overlap the store stay valid.
- R4: `line_inval` removes every reservation.
- R5: A load-linked request fills the lowest-numbered free slot. A slot freed by a store or invalidate in the same cycle counts as free.
- R6: When no slot is free, the load-linked request overwrites the slot named by a replacement pointer. The pointer is 0 after reset and steps by one, wrapping, after each overwrite.
- R7: When a load-linked request arrives in the same cycle as a store or invalidate, the removals are applied first. The new reservation is then inserted and survives.
- R8: A synchronous active-high `rst` removes all reservations, resets the replacement pointer, and drives `sc_done` and `sc_ok` low.
- R9: `sc_done` is high in the cycle after a conditional store, and only then. `sc_ok` is never high without `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked request this cycle |
| ll_ctx | input | CTX_W | Context of the load-linked request |
| ll_addr | input | ADDR_W | Byte address of the load-linked request |
| ll_size | input | 2 | Size code of the load-linked request |
| st_valid | input | 1 | Store request this cycle |
| st_cond | input | 1 | The store is conditional |
| st_ctx | input | CTX_W | Context of the store |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| line_inval | input | 1 | Remove every reservation on the line |
| sc_done | output | 1 | A conditional-store verdict is presented |
| sc_ok | output | 1 | Verdict: 1 success, 0 failure |

## Verification
One swept pattern holds a fixed 4-byte reservation and walks plain stores of every size over addresses on both sides of it. A conditional store then probes the reservation, which separates overlapping stores from stores that only touch neighbouring bytes. A second sweep probes an 8-byte reservation with conditional stores at every offset and size. This shows where full containment ends and partial overlap begins. Mixed-context and table-full patterns, along with same-cycle load-linked/store/invalidate patterns, show which slot is filled or overwritten and in which order removal and insertion take effect. A long pseudo-random stream over a narrow address window is compared against an arithmetic model of the table.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Access size code carried on the request ports
    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_size_e;

    // Byte count for a size code
    function automatic logic [3:0] size_bytes(input acc_size_e code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/rsv_span.sv
module rsv_span
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic [ADDR_W:0]   lo_o,
    output logic [ADDR_W:0]   hi_o
);
    // One extra bit so the span end never wraps
    localparam int SPAN_W = ADDR_W + 1;

    acc_size_e code;

    always_comb begin
        code = acc_size_e'(size_i);
        lo_o = {1'b0, addr_i};
        hi_o = lo_o + SPAN_W'(size_bytes(code)) - SPAN_W'(1);
    end
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot #(
    parameter int ADDR_W = 32,
    parameter int CTX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kill_i,
    input  logic              load_i,
    input  logic [CTX_W-1:0]  ld_ctx_i,
    input  logic [ADDR_W:0]   ld_lo_i,
    input  logic [ADDR_W:0]   ld_hi_i,
    input  logic [CTX_W-1:0]  q_ctx_i,
    input  logic [ADDR_W:0]   q_lo_i,
    input  logic [ADDR_W:0]   q_hi_i,
    output logic              valid_o,
    output logic              touch_o,
    output logic              covers_o
);
    logic              valid_q;
    logic [CTX_W-1:0]  ctx_q;
    logic [ADDR_W:0]   lo_q;
    logic [ADDR_W:0]   hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
        end else if (kill_i) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            ctx_q <= ld_ctx_i;
            lo_q  <= ld_lo_i;
            hi_q  <= ld_hi_i;
        end
    end

    always_comb begin
        valid_o  = valid_q;
        touch_o  = valid_q && (q_lo_i <= hi_q) && (q_hi_i >= lo_q);
        covers_o = valid_q && (q_ctx_i == ctx_q) &&
                   (q_lo_i >= lo_q) && (q_hi_i <= hi_q);
    end
endmodule

// File: rtl/rsv_pick.sv
module rsv_pick #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic [N_SLOTS-1:0] free_i,
    output logic [N_SLOTS-1:0] sel_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

    logic [IDX_W-1:0] rr_q;
    logic             have_free;

    always_comb begin
        have_free = 1'b0;
        sel_o     = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (!have_free && free_i[i]) begin
                sel_o[i]  = 1'b1;
                have_free = 1'b1;
            end
        end
        if (!have_free) begin
            sel_o[rr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (req_i && !have_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
    parameter int ADDR_W  = 32,
    parameter int CTX_W   = 4,
    parameter int N_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_valid,
    input  logic [CTX_W-1:0]  ll_ctx,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic [1:0]        ll_size,
    input  logic              st_valid,
    input  logic              st_cond,
    input  logic [CTX_W-1:0]  st_ctx,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              line_inval,
    output logic              sc_done,
    output logic              sc_ok
);
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic [ADDR_W:0]    ll_lo, ll_hi, st_lo, st_hi;
    logic [N_SLOTS-1:0] valid_q, touch, covers, kill, free, pick;

    rsv_span #(.ADDR_W(ADDR_W)) u_ll_span (
        .addr_i(ll_addr), .size_i(ll_size), .lo_o(ll_lo), .hi_o(ll_hi)
    );

    rsv_span #(.ADDR_W(ADDR_W)) u_st_span (
        .addr_i(st_addr), .size_i(st_size), .lo_o(st_lo), .hi_o(st_hi)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign kill[g] = line_inval | (st_valid & touch[g]);
        assign free[g] = ~(valid_q[g] & ~kill[g]);

        rsv_slot #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .kill_i   (kill[g]),
            .load_i   (ll_valid & pick[g]),
            .ld_ctx_i (ll_ctx),
            .ld_lo_i  (ll_lo),
            .ld_hi_i  (ll_hi),
            .q_ctx_i  (st_ctx),
            .q_lo_i   (st_lo),
            .q_hi_i   (st_hi),
            .valid_o  (valid_q[g]),
            .touch_o  (touch[g]),
            .covers_o (covers[g])
        );
    end

    rsv_pick #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .req_i  (ll_valid),
        .free_i (free),
        .sel_o  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_done <= 1'b0;
            sc_ok   <= 1'b0;
        end else begin
            sc_done <= st_valid & st_cond;
            sc_ok   <= st_valid & st_cond & (|covers);
        end
    end
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
    parameter int N_SLOTS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ll_valid,
    input logic               st_valid,
    input logic               st_cond,
    input logic               line_inval,
    input logic               sc_done,
    input logic               sc_ok,
    input logic [N_SLOTS-1:0] valid_q
);
    // R9
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        sc_ok |-> sc_done);

    // R9
    done_follows_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_cond) |=> sc_done);

    // R9
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(st_valid && st_cond) |=> !sc_done);

    // R4
    inval_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (line_inval && !ll_valid) |=> (valid_q == '0));

    // R7
    ll_survives_chk: assert property (@(posedge clk) disable iff (rst)
        ll_valid |=> (valid_q != '0));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sc_done && !sc_ok && valid_q == '0));
endmodule

bind rsv_monitor rsv_monitor_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ll_valid   (ll_valid),
    .st_valid   (st_valid),
    .st_cond    (st_cond),
    .line_inval (line_inval),
    .sc_done    (sc_done),
    .sc_ok      (sc_ok),
    .valid_q    (valid_q)
);

// File: tb/rsv_monitor_tb_top.sv
module rsv_monitor_tb_top;
    localparam int AW = 8;
    localparam int CW = 2;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ll_valid, st_valid, st_cond, line_inval;
    logic [CW-1:0] ll_ctx, st_ctx;
    logic [AW-1:0] ll_addr, st_addr;
    logic [1:0]    ll_size, st_size;
    logic          sc_done, sc_ok;

    int errors = 0;
    int checks = 0;

    // reference table
    bit m_v[NS];
    int m_ctx[NS];
    int m_lo[NS];
    int m_hi[NS];
    int m_rr;

    always #5ns clk = ~clk;

    rsv_monitor #(.ADDR_W(AW), .CTX_W(CW), .N_SLOTS(NS)) dut_i (
        .clk(clk), .rst(rst),
        .ll_valid(ll_valid), .ll_ctx(ll_ctx), .ll_addr(ll_addr), .ll_size(ll_size),
        .st_valid(st_valid), .st_cond(st_cond), .st_ctx(st_ctx),
        .st_addr(st_addr), .st_size(st_size),
        .line_inval(line_inval), .sc_done(sc_done), .sc_ok(sc_ok)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp_v);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic idle_inputs();
        ll_valid = 0; st_valid = 0; st_cond = 0; line_inval = 0;
        ll_ctx = 0; st_ctx = 0; ll_addr = 0; st_addr = 0; ll_size = 0; st_size = 0;
    endtask

    task automatic model_clear();
        for (int i = 0; i < NS; i++) m_v[i] = 0;
        m_rr = 0;
    endtask

    // one cycle of stimulus; starts and ends at a falling edge
    task automatic step(input bit ll, input int lc, input int la, input int ls,
                        input bit st, input bit cd, input int sc, input int sa, input int ss,
                        input bit inv, input string req);
        int shi, slot;
        bit exp_ok;
        shi = sa + (1 << ss) - 1;
        exp_ok = 0;
        for (int i = 0; i < NS; i++)
            if (m_v[i] && m_ctx[i] == sc && sa >= m_lo[i] && shi <= m_hi[i]) exp_ok = 1;
        for (int i = 0; i < NS; i++)
            if (m_v[i] && (inv || (st && sa <= m_hi[i] && shi >= m_lo[i]))) m_v[i] = 0;
        if (ll) begin
            slot = -1;
            for (int i = NS - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % NS;
            end
            m_v[slot] = 1; m_ctx[slot] = lc;
            m_lo[slot] = la; m_hi[slot] = la + (1 << ls) - 1;
        end
        ll_valid = ll; ll_ctx = CW'(lc); ll_addr = AW'(la); ll_size = 2'(ls);
        st_valid = st; st_cond = cd; st_ctx = CW'(sc); st_addr = AW'(sa); st_size = 2'(ss);
        line_inval = inv;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        chk(sc_done == (st && cd), "R9", int'(sc_done), int'(st && cd));
        if (st && cd) chk(sc_ok == exp_ok, req, int'(sc_ok), int'(exp_ok));
    endtask

    task automatic do_ll(input int c, input int a, input int s);
        step(1, c, a, s, 0, 0, 0, 0, 0, 0, "R5");
    endtask
    task automatic do_st(input int c, input int a, input int s);
        step(0, 0, 0, 0, 1, 0, c, a, s, 0, "R3");
    endtask
    task automatic do_sc(input int c, input int a, input int s, input string req);
        step(0, 0, 0, 0, 1, 1, c, a, s, 0, req);
    endtask
    task automatic do_inv();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
    endtask

    initial begin
        idle_inputs();
        model_clear();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: outputs quiet in reset
        chk(sc_done == 0 && sc_ok == 0, "R8", int'(sc_ok), 0);
        rst = 0;
        // R8: no reservation after reset
        do_sc(0, 0, 0, "R8");

        // R3: plain stores of every size around a 4-byte reservation at 16..19
        for (int a = 8; a < 28; a++) begin
            for (int s = 0; s < 4; s++) begin
                do_inv();
                do_ll(0, 16, 2);
                do_st(1, a, s);
                do_sc(0, 16, 2, "R3");
            end
        end

        // R1/R2: containment probe against an 8-byte reservation at 16..23
        for (int a = 12; a < 28; a++) begin
            for (int s = 0; s < 4; s++) begin
                do_inv();
                do_ll(1, 16, 3);
                do_sc(1, a, s, "R2");
            end
        end

        // R2: wrong context fails, and the failed store still removes it (R3)
        do_inv();
        do_ll(2, 40, 2);
        do_sc(3, 40, 2, "R2");
        do_sc(2, 40, 2, "R3");

        // R4: invalidate removes everything
        do_ll(0, 0, 3);
        do_ll(1, 8, 3);
        do_inv();
        do_sc(0, 0, 3, "R4");
        do_sc(1, 8, 3, "R4");

        // R5/R6: fill, free a middle slot, refill, then overwrite in order
        do_inv();
        for (int k = 0; k < NS; k++) do_ll(k % 4, 8 * k, 2);
        do_st(3, 8, 0);
        do_ll(1, 40, 2);
        do_ll(2, 48, 2);
        do_ll(3, 56, 2);
        do_sc(0, 0, 2, "R6");
        do_sc(1, 40, 2, "R5");
        do_sc(2, 16, 2, "R6");
        do_sc(2, 48, 2, "R6");
        do_sc(3, 56, 2, "R6");
        do_sc(3, 24, 2, "R6");

        // R7: same-cycle load-linked and overlapping store, and with invalidate
        do_inv();
        step(1, 2, 64, 2, 1, 0, 1, 64, 2, 0, "R7");
        do_sc(2, 64, 2, "R7");
        do_ll(1, 80, 2);
        step(1, 1, 88, 2, 0, 0, 0, 0, 0, 1, "R7");
        do_sc(1, 80, 2, "R7");
        do_sc(1, 88, 2, "R7");
        // R2: verdict uses table before same-cycle insert
        step(1, 0, 96, 2, 1, 1, 0, 96, 2, 0, "R2");
        do_sc(0, 96, 2, "R7");

        // random stream on a narrow window
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom);
            step(r[0], r[3:2], r[8:4], r[10:9],
                 r[11], r[12], r[14:13], r[19:15], r[21:20],
                 (r[27:23] == 0), "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(1_500_000ns);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule